// File: doc/BRIEF.md
# Multicycle ALU with Serial Shifter

This block is the arithmetic engine of a small sequencer core. It holds eight 16-bit general registers and a 16-bit immediate register that is filled one byte at a time. A sequencer presents an opcode, two source selects, a destination select and a `start` strobe. Add, subtract, logic masks, copy, byte swap and the fixed 8-position shifts finish in one clock. Multiply and variable shifts run over many clocks, and a `busy`/`done` handshake tells the sequencer when the result is in place.

Multiply uses a radix-2 shift-and-add loop. Its 32-bit product always lands in a fixed register pair: register 6 gets the upper half and register 7 the lower half. That same pair can be shifted as one 32-bit word. Variable shifts advance one bit position per clock and overwrite their operand register. A condition register keeps a carry/borrow flag, a saturation flag and two mask-result flags. Register contents can be read back through a combinational read port.

Top module: `malu_top`

## Requirements
- R1: After reset, all eight registers read 0, `busy` and `done` are low and all four flags are low.
- R2: ADD (op 0) and SUB (op 1) write `A + B` or `A - B` (modulo 2^16) to the destination in the clock edge that samples `start`. `done` is high in the following cycle and `busy` stays low. `flag_c` takes the carry-out (ADD) or the borrow (SUB).
- R3: With `sat_en` high, an ADD that carries writes 0xFFFF and a SUB that borrows writes 0x0000, and `flag_sat` is set. `flag_sat` is cleared by any ADD or SUB that does not clamp.
- R4: AND (op 2), OR (op 3) and XOR (op 4) write their result in one clock. Each sets `flag_mmax` when the result is 0xFFFF and `flag_mmin` when it is 0x0000.
- R5: `imm_ld_hi` loads `imm_byte` into bits 15:8 of the immediate register and `imm_ld_lo` loads it into bits 7:0, each without touching the other byte. MOV (op 5) copies the B operand, which is the immediate when `use_imm` is high, to the destination.
- R6: SWAP (op 6) exchanges bits 15:8 with bits 7:0. SHL8 (op 7) and SHR8 (op 8) shift by eight with zero fill. All three finish in one clock.
- R7: MUL (op 9) keeps `busy` high for exactly 16 cycles. It then writes the unsigned 32-bit product of A and B to register 6 (bits 31:16) and register 7 (bits 15:0).
- R8: SHL (op 10) and SHR (op 11) shift register A in place by B[4:0] positions, one per clock, with `busy` high for that many cycles. Counts above 16 act as 16. A count of 0 completes in one clock with no `busy` and leaves the register unchanged.
- R9: ASR (op 12) and ASL (op 13) keep bit 15 fixed during every step. ASR copies bit 15 into bit 14. ASL shifts bits 14:0 left.
- R10: SHL32 (op 14) and SHR32 (op 15) shift the pair {register 6, register 7} as one 32-bit word, so bits cross between bit 0 of register 6 and bit 15 of register 7.
- R11: `done` is a one-cycle pulse that rises in the same cycle `busy` falls, and `busy` and `done` are never high together.
- R12: A `start` that arrives while `busy` is high is ignored. No register is written because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the operation on `op` (taken only while not busy) |
| op | input | 4 | Opcode, encodings listed in the requirements |
| sel_a | input | 3 | Source A register; also the in-place target of 16-bit variable shifts |
| sel_b | input | 3 | Source B register; its bits 4:0 give the shift count |
| sel_d | input | 3 | Destination register for single-clock operations |
| use_imm | input | 1 | Take B from the immediate register |
| sat_en | input | 1 | Unsigned saturation for ADD/SUB |
| imm_byte | input | 8 | Byte to load into the immediate register |
| imm_ld_hi | input | 1 | Load `imm_byte` into immediate bits 15:8 |
| imm_ld_lo | input | 1 | Load `imm_byte` into immediate bits 7:0 |
| rd_sel | input | 3 | Read-port register select |
| rd_data | output | 16 | Contents of register `rd_sel` |
| busy | output | 1 | Multicycle operation in progress |
| done | output | 1 | Operation finished, result written |
| flag_c | output | 1 | Carry from ADD, borrow from SUB |
| flag_sat | output | 1 | Last ADD/SUB clamped |
| flag_mmax | output | 1 | Last mask result was 0xFFFF |
| flag_mmin | output | 1 | Last mask result was 0x0000 |

## Verification
The hardest case to reach from the ports is a second `start` that arrives in the middle of a multiply. Here the engine holds operands it captured earlier, the single-clock path is pointed at a register it must not touch, and the pulse has to lose to the running operation. The stimulus first places a known value in register 5. It then launches a multiply and, while `busy` is high, holds `start` for two cycles with a MOV of the immediate into register 5. Afterwards it confirms that register 5 is intact and that the product is still correct. Pair shifts are steered so that a bit crosses the boundary between the two product registers in both directions.

// File: rtl/malu_pkg.sv
package malu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_MOV   = 4'd5,
    OP_SWAP  = 4'd6,
    OP_SHL8  = 4'd7,
    OP_SHR8  = 4'd8,
    OP_MUL   = 4'd9,
    OP_SHL   = 4'd10,
    OP_SHR   = 4'd11,
    OP_ASR   = 4'd12,
    OP_ASL   = 4'd13,
    OP_SHL32 = 4'd14,
    OP_SHR32 = 4'd15
  } malu_op_e;

  function automatic logic op_is_iter(malu_op_e o);
    return o >= OP_MUL;
  endfunction

  function automatic logic op_is_shift(malu_op_e o);
    return o >= OP_SHL;
  endfunction

  function automatic logic op_is_pair(malu_op_e o);
    return (o == OP_MUL) || (o == OP_SHL32) || (o == OP_SHR32);
  endfunction

endpackage

// File: rtl/malu_regfile.sv
module malu_regfile #(
  parameter int W    = 16,
  parameter int N    = 8,
  parameter int HI   = 6,
  parameter int LO   = 7,
  localparam int SW  = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SW-1:0]  ra_sel,
  input  logic [SW-1:0]  rb_sel,
  input  logic [SW-1:0]  rx_sel,
  output logic [W-1:0]   ra,
  output logic [W-1:0]   rb,
  output logic [W-1:0]   rx,
  output logic [2*W-1:0] pair_q,
  input  logic           wr_en,
  input  logic [SW-1:0]  wr_sel,
  input  logic [W-1:0]   wr_data,
  input  logic           pr_en,
  input  logic [2*W-1:0] pr_data
);
  logic [W-1:0] rv [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (wr_en && wr_sel == SW'(i))
        q <= wr_data;
      else if (pr_en && i == HI)
        q <= pr_data[2*W-1:W];
      else if (pr_en && i == LO)
        q <= pr_data[W-1:0];
    end
    assign rv[i] = q;
  end

  assign ra     = rv[ra_sel];
  assign rb     = rv[rb_sel];
  assign rx     = rv[rx_sel];
  assign pair_q = {rv[HI], rv[LO]};
endmodule

// File: rtl/malu_immreg.sv
module malu_immreg #(
  parameter int W = 16,
  localparam int H = W / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [H-1:0] byte_in,
  input  logic         ld_hi,
  input  logic         ld_lo,
  output logic [W-1:0] imm
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm <= '0;
    end else begin
      if (ld_hi) imm[W-1:H] <= byte_in;
      if (ld_lo) imm[H-1:0] <= byte_in;
    end
  end
endmodule

// File: rtl/malu_comb.sv
module malu_comb
  import malu_pkg::*;
#(
  parameter int W = 16,
  localparam int H = W / 2
) (
  input  malu_op_e     op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sat_en,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         arith,
  output logic         mask
);
  function automatic logic [W:0] wide_add(logic [W-1:0] x, logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [W:0] wide_sub(logic [W-1:0] x, logic [W-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  function automatic logic [W-1:0] clamp(logic [W:0] s, logic en, logic is_sub);
    if (en && s[W]) return is_sub ? '0 : '1;
    return s[W-1:0];
  endfunction

  logic [W:0] sum_w, dif_w;
  assign sum_w = wide_add(a, b);
  assign dif_w = wide_sub(a, b);

  always_comb begin
    res   = '0;
    carry = 1'b0;
    arith = 1'b0;
    mask  = 1'b0;
    unique case (op)
      OP_ADD:  begin res = clamp(sum_w, sat_en, 1'b0); carry = sum_w[W]; arith = 1'b1; end
      OP_SUB:  begin res = clamp(dif_w, sat_en, 1'b1); carry = dif_w[W]; arith = 1'b1; end
      OP_AND:  begin res = a & b; mask = 1'b1; end
      OP_OR:   begin res = a | b; mask = 1'b1; end
      OP_XOR:  begin res = a ^ b; mask = 1'b1; end
      OP_MOV:  res = b;
      OP_SWAP: res = {a[H-1:0], a[W-1:H]};
      OP_SHL8: res = {a[H-1:0], {H{1'b0}}};
      OP_SHR8: res = {{H{1'b0}}, a[W-1:H]};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/malu_iter.sv
module malu_iter
  import malu_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  malu_op_e       op_i,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic [2*W-1:0] pair_i,
  input  logic [CW-1:0]  cnt_i,
  output logic           busy,
  output logic           last,
  output malu_op_e       kind,
  output logic [2*W-1:0] res
);
  logic [2*W-1:0] p_q, p_nx;
  logic [W-1:0]   mcand_q;
  logic [CW-1:0]  cnt_q;
  logic [W:0]     psum;

  assign psum = {1'b0, p_q[2*W-1:W]} + (p_q[0] ? {1'b0, mcand_q} : '0);

  always_comb begin
    unique case (kind)
      OP_MUL:   p_nx = {psum, p_q[W-1:1]};
      OP_SHL:   p_nx = {p_q[2*W-1:W], p_q[W-2:0], 1'b0};
      OP_SHR:   p_nx = {p_q[2*W-1:W], 1'b0, p_q[W-1:1]};
      OP_ASR:   p_nx = {p_q[2*W-1:W], p_q[W-1], p_q[W-1:1]};
      OP_ASL:   p_nx = {p_q[2*W-1:W], p_q[W-1], p_q[W-3:0], 1'b0};
      OP_SHL32: p_nx = {p_q[2*W-2:0], 1'b0};
      OP_SHR32: p_nx = {1'b0, p_q[2*W-1:1]};
      default:  p_nx = p_q;
    endcase
  end

  assign last = busy && (cnt_q == CW'(1));
  assign res  = p_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      kind    <= OP_ADD;
      p_q     <= '0;
      mcand_q <= '0;
      cnt_q   <= '0;
    end else if (go) begin
      busy    <= 1'b1;
      kind    <= op_i;
      mcand_q <= opa;
      if (op_i == OP_MUL) begin
        p_q   <= {{W{1'b0}}, opb};
        cnt_q <= CW'(W);
      end else begin
        p_q   <= op_is_pair(op_i) ? pair_i : {{W{1'b0}}, opa};
        cnt_q <= cnt_i;
      end
    end else if (busy) begin
      p_q   <= p_nx;
      cnt_q <= cnt_q - 1'b1;
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/malu_top.sv
module malu_top
  import malu_pkg::*;
#(
  parameter int W      = 16,
  parameter int NREG   = 8,
  parameter int HI_IDX = 6,
  parameter int LO_IDX = 7,
  localparam int SW    = $clog2(NREG),
  localparam int H     = W / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    op,
  input  logic [SW-1:0] sel_a,
  input  logic [SW-1:0] sel_b,
  input  logic [SW-1:0] sel_d,
  input  logic          use_imm,
  input  logic          sat_en,
  input  logic [H-1:0]  imm_byte,
  input  logic          imm_ld_hi,
  input  logic          imm_ld_lo,
  input  logic [SW-1:0] rd_sel,
  output logic [W-1:0]  rd_data,
  output logic          busy,
  output logic          done,
  output logic          flag_c,
  output logic          flag_sat,
  output logic          flag_mmax,
  output logic          flag_mmin
);
  localparam int CW = $clog2(W) + 1;

  malu_op_e       op_e;
  logic [W-1:0]   ra, rb, imm_q, bop, c_res;
  logic [2*W-1:0] pair_q, it_res;
  logic           c_carry, c_arith, c_mask;
  logic [CW-1:0]  cnt_raw, cnt_c;
  logic           accept, zero_sh, go, single, last_step;
  malu_op_e       it_kind;
  logic [SW-1:0]  dest_q;

  // named internal events
  logic           wr_en, pr_en, sh_wr, arith_evt, mask_evt, sat_evt;
  logic [SW-1:0]  wr_sel;
  logic [W-1:0]   wr_data;

  assign op_e    = malu_op_e'(op);
  assign bop     = use_imm ? imm_q : rb;
  assign cnt_raw = bop[CW-1:0];
  assign cnt_c   = (cnt_raw > CW'(W)) ? CW'(W) : cnt_raw;

  assign accept  = start && !busy;
  assign zero_sh = op_is_shift(op_e) && (cnt_c == '0);
  assign go      = accept && op_is_iter(op_e) && !zero_sh;
  assign single  = accept && !go;

  assign sh_wr   = last_step && !op_is_pair(it_kind);
  assign pr_en   = last_step && op_is_pair(it_kind);
  assign wr_en   = sh_wr || (single && !op_is_iter(op_e));
  assign wr_sel  = sh_wr ? dest_q : sel_d;
  assign wr_data = sh_wr ? it_res[W-1:0] : c_res;

  assign arith_evt = single && c_arith;
  assign mask_evt  = single && c_mask;
  assign sat_evt   = arith_evt && sat_en && c_carry;

  malu_regfile #(.W(W), .N(NREG), .HI(HI_IDX), .LO(LO_IDX)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_sel(sel_a), .rb_sel(sel_b), .rx_sel(rd_sel),
    .ra(ra), .rb(rb), .rx(rd_data), .pair_q(pair_q),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pr_en(pr_en), .pr_data(it_res)
  );

  malu_immreg #(.W(W)) u_imm (
    .clk(clk), .rst_n(rst_n), .byte_in(imm_byte),
    .ld_hi(imm_ld_hi), .ld_lo(imm_ld_lo), .imm(imm_q)
  );

  malu_comb #(.W(W)) u_comb (
    .op(op_e), .a(ra), .b(bop), .sat_en(sat_en),
    .res(c_res), .carry(c_carry), .arith(c_arith), .mask(c_mask)
  );

  malu_iter #(.W(W), .CW(CW)) u_iter (
    .clk(clk), .rst_n(rst_n), .go(go), .op_i(op_e),
    .opa(ra), .opb(bop), .pair_i(pair_q), .cnt_i(cnt_c),
    .busy(busy), .last(last_step), .kind(it_kind), .res(it_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q    <= '0;
      done      <= 1'b0;
      flag_c    <= 1'b0;
      flag_sat  <= 1'b0;
      flag_mmax <= 1'b0;
      flag_mmin <= 1'b0;
    end else begin
      done <= single || last_step;
      if (go) dest_q <= sel_a;
      if (arith_evt) begin
        flag_c   <= c_carry;
        flag_sat <= sat_en && c_carry;
      end
      if (mask_evt) begin
        flag_mmax <= (c_res == '1);
        flag_mmin <= (c_res == '0);
      end
    end
  end
endmodule

// File: rtl/malu_chk.sv
module malu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic         mask_evt,
  input logic         flag_mmax,
  input logic         flag_mmin,
  input logic         sat_evt,
  input logic         last_step
);
  logic [7:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= '0;
    else if (busy)  run_len <= run_len + 8'd1;
    else            run_len <= '0;
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < 8'(2*W))) else $error("busy too long"); // R7

  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done) else $error("no done at busy fall"); // R11

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)) else $error("busy and done together"); // R11

  AST_MASK_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt |=> (flag_mmax == ($past(wr_data) == '1))) else $error("mask max flag"); // R4

  AST_MASK_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt |=> (flag_mmin == ($past(wr_data) == '0))) else $error("mask min flag"); // R4

  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |-> (wr_data == '1 || wr_data == '0)) else $error("no clamp"); // R3

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |-> !wr_en) else $error("write while busy"); // R12
endmodule

bind malu_top malu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .wr_en(wr_en), .wr_data(wr_data), .mask_evt(mask_evt),
  .flag_mmax(flag_mmax), .flag_mmin(flag_mmin),
  .sat_evt(sat_evt), .last_step(last_step)
);

// File: tb/sim_malu_top.sv
`timescale 1ns/1ps
module sim_malu_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, use_imm = 0, sat_en = 0, imm_ld_hi = 0, imm_ld_lo = 0;
  logic [3:0] op = 0;
  logic [2:0] sel_a = 0, sel_b = 0, sel_d = 0, rd_sel = 0;
  logic [7:0] imm_byte = 0;
  logic [15:0] rd_data;
  logic busy, done, flag_c, flag_sat, flag_mmax, flag_mmin;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  malu_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .sel_a(sel_a), .sel_b(sel_b), .sel_d(sel_d), .use_imm(use_imm), .sat_en(sat_en),
    .imm_byte(imm_byte), .imm_ld_hi(imm_ld_hi), .imm_ld_lo(imm_ld_lo),
    .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy), .done(done),
    .flag_c(flag_c), .flag_sat(flag_sat), .flag_mmax(flag_mmax), .flag_mmin(flag_mmin)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic        sat;
    logic [15:0] res;
    logic        chk_c;
    logic        exp_c;
    logic        chk_m;
    logic        exp_mx;
    logic        exp_mn;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{4'd0, 16'h1234, 16'h0101, 1'b0, 16'h1335, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd0, 16'hFFF0, 16'h0020, 1'b0, 16'h0010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd0, 16'hFFF0, 16'h0020, 1'b1, 16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd1, 16'h0005, 16'h0007, 1'b0, 16'hFFFE, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd1, 16'h0005, 16'h0007, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd1, 16'h0100, 16'h0001, 1'b1, 16'h00FF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd6, 16'h12AB, 16'h0000, 1'b0, 16'hAB12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd7, 16'h12AB, 16'h0000, 1'b0, 16'hAB00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd8, 16'h12AB, 16'h0000, 1'b0, 16'h0012, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd2, 16'hF0F0, 16'h0FF0, 1'b0, 16'h00F0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{4'd3, 16'hF0F0, 16'h0F0F, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{4'd4, 16'hAAAA, 16'hAAAA, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic put_imm(input logic [15:0] v);
    imm_byte = v[15:8]; imm_ld_hi = 1;
    @(negedge clk);
    imm_ld_hi = 0; imm_byte = v[7:0]; imm_ld_lo = 1;
    @(negedge clk);
    imm_ld_lo = 0;
  endtask

  task automatic run(input logic [3:0] o, input logic [2:0] a, input logic [2:0] b,
                     input logic [2:0] d, input logic ui, input logic sat, output int bcyc);
    int guard;
    op = o; sel_a = a; sel_b = b; sel_d = d; use_imm = ui; sat_en = sat; start = 1;
    @(negedge clk);
    start = 0;
    bcyc = 0; guard = 0;
    while (!done && guard < 200) begin
      if (busy) bcyc++;
      @(negedge clk);
      guard++;
    end
    if (!done) chk("R11", "done never seen", 0, 1);
  endtask

  task automatic get_reg(input logic [2:0] r, output logic [15:0] v);
    rd_sel = r; #1; v = rd_data;
  endtask

  task automatic set_reg(input logic [2:0] r, input logic [15:0] v);
    int c;
    put_imm(v);
    run(4'd5, 3'd0, 3'd0, r, 1'b1, 1'b0, c);
  endtask

  function automatic logic [15:0] asr_ref(logic [15:0] x, int n);
    logic [15:0] y = x;
    for (int i = 0; i < n; i++) y = {y[15], y[15:1]};
    return y;
  endfunction

  function automatic logic [15:0] asl_ref(logic [15:0] x, int n);
    return {x[15], 15'(x[14:0] << n)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v6, v7;
    logic [31:0] prod;
    int c;
    string tag;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < 8; r++) begin
      get_reg(3'(r), v);
      chk("R1", "reg after reset", {16'h0, v}, 32'h0);
    end
    chk("R1", "busy/done/flags", {busy, done, flag_c, flag_sat, flag_mmax, flag_mmin}, 0);

    // R5 byte-wise immediate loading
    imm_byte = 8'h5A; imm_ld_hi = 1; @(negedge clk); imm_ld_hi = 0;
    run(4'd5, 3'd0, 3'd0, 3'd4, 1'b1, 1'b0, c);
    get_reg(3'd4, v); chk("R5", "hi byte only", {16'h0, v}, 32'h5A00);
    imm_byte = 8'h3C; imm_ld_lo = 1; @(negedge clk); imm_ld_lo = 0;
    run(4'd5, 3'd0, 3'd0, 3'd4, 1'b1, 1'b0, c);
    get_reg(3'd4, v); chk("R5", "lo byte only", {16'h0, v}, 32'h5A3C);
    imm_byte = 8'h77; imm_ld_hi = 1; @(negedge clk); imm_ld_hi = 0;
    run(4'd5, 3'd0, 3'd0, 3'd4, 1'b1, 1'b0, c);
    get_reg(3'd4, v); chk("R5", "hi reload keeps lo", {16'h0, v}, 32'h773C);

    // vector table: single-clock operations
    for (int i = 0; i < NV; i++) begin
      vec_t e = VT[i];
      if (e.op == 4'd0 || e.op == 4'd1) tag = e.sat ? "R3" : "R2";
      else if (e.op >= 4'd2 && e.op <= 4'd4) tag = "R4";
      else tag = "R6";
      set_reg(3'd1, e.a);
      set_reg(3'd2, e.b);
      run(e.op, 3'd1, 3'd2, 3'd3, 1'b0, e.sat, c);
      chk(tag, "one-clock done without busy", c, 0);
      get_reg(3'd3, v);
      chk(tag, "result", {16'h0, v}, {16'h0, e.res});
      if (e.chk_c) chk(tag, "carry/sat flags", {flag_c, flag_sat}, {e.exp_c, e.sat & e.exp_c});
      if (e.chk_m) chk(tag, "mask flags", {flag_mmax, flag_mmin}, {e.exp_mx, e.exp_mn});
    end

    // R7 multiply
    set_reg(3'd1, 16'hFFFF); set_reg(3'd2, 16'hFFFF);
    run(4'd9, 3'd1, 3'd2, 3'd0, 1'b0, 1'b0, c);
    chk("R7", "mul busy cycles", c, 16);
    prod = 32'hFFFF * 32'hFFFF;
    get_reg(3'd6, v6); get_reg(3'd7, v7);
    chk("R7", "product ffff*ffff", {v6, v7}, prod);
    @(negedge clk);
    chk("R11", "done pulse ends", {31'h0, done}, 0);
    set_reg(3'd1, 16'h1234); set_reg(3'd2, 16'h0010);
    run(4'd9, 3'd1, 3'd2, 3'd0, 1'b0, 1'b0, c);
    get_reg(3'd6, v6); get_reg(3'd7, v7);
    chk("R7", "product 1234*10", {v6, v7}, 32'h1234 * 32'h0010);

    // R8 variable shifts
    set_reg(3'd1, 16'h8001); set_reg(3'd2, 16'd3);
    run(4'd10, 3'd1, 3'd2, 3'd0, 1'b0, 1'b0, c);
    get_reg(3'd1, v);
    chk("R8", "shl by 3", {16'h0, v}, {16'h0, 16'h8001 << 3});
    chk("R8", "shl busy cycles", c, 3);
    set_reg(3'd1, 16'h8001);
    run(4'd11, 3'd1, 3'd2, 3'd0, 1'b0, 1'b0, c);
    get_reg(3'd1, v);
    chk("R8", "shr by 3", {16'h0, v}, {16'h0, 16'h8001 >> 3});
    set_reg(3'd1, 16'hFFFF); set_reg(3'd2, 16'd16);
    run(4'd10, 3'd1, 3'd2, 3'd0, 1'b0, 1'b0, c);
    get_reg(3'd1, v);
    chk("R8", "shl by 16", {16'h0, v}, 0);
    chk("R8", "busy for 16", c, 16);
    set_reg(3'd1, 16'hFFFF); set_reg(3'd2, 16'd20);
    run(4'd11, 3'd1, 3'd2, 3'd0, 1'b0, 1'b0, c);
    chk("R8", "count 20 clamps to 16", c, 16);
    get_reg(3'd1, v);
    chk("R8", "shr clamped result", {16'h0, v}, 0);
    set_reg(3'd1, 16'h1234); set_reg(3'd2, 16'd0);
    run(4'd10, 3'd1, 3'd2, 3'd0, 1'b0, 1'b0, c);
    chk("R8", "zero count no busy", c, 0);
    get_reg(3'd1, v);
    chk("R8", "zero count unchanged", {16'h0, v}, 32'h1234);

    // R9 signed shifts
    set_reg(3'd1, 16'h8001); set_reg(3'd2, 16'd3);
    run(4'd12, 3'd1, 3'd2, 3'd0, 1'b0, 1'b0, c);
    get_reg(3'd1, v);
    chk("R9", "asr keeps msb", {16'h0, v}, {16'h0, asr_ref(16'h8001, 3)});
    set_reg(3'd1, 16'h8001);
    run(4'd13, 3'd1, 3'd2, 3'd0, 1'b0, 1'b0, c);
    get_reg(3'd1, v);
    chk("R9", "asl keeps msb", {16'h0, v}, {16'h0, asl_ref(16'h8001, 3)});
    set_reg(3'd1, 16'h4001);
    run(4'd13, 3'd1, 3'd2, 3'd0, 1'b0, 1'b0, c);
    get_reg(3'd1, v);
    chk("R9", "asl clear msb stays clear", {16'h0, v}, {16'h0, asl_ref(16'h4001, 3)});

    // R10 pair shifts across the register boundary
    set_reg(3'd6, 16'h0001); set_reg(3'd7, 16'h8000); set_reg(3'd2, 16'd1);
    run(4'd14, 3'd0, 3'd2, 3'd0, 1'b0, 1'b0, c);
    get_reg(3'd6, v6); get_reg(3'd7, v7);
    chk("R10", "shl32 crosses up", {v6, v7}, 32'h0001_8000 << 1);
    set_reg(3'd2, 16'd4);
    run(4'd15, 3'd0, 3'd2, 3'd0, 1'b0, 1'b0, c);
    get_reg(3'd6, v6); get_reg(3'd7, v7);
    chk("R10", "shr32 crosses down", {v6, v7}, (32'h0001_8000 << 1) >> 4);
    chk("R10", "shr32 busy cycles", c, 4);

    // R12 start during busy ignored
    set_reg(3'd5, 16'h0BAD);
    set_reg(3'd1, 16'h0123); set_reg(3'd2, 16'h0045);
    put_imm(16'hDEAD);
    op = 4'd9; sel_a = 3'd1; sel_b = 3'd2; use_imm = 0; start = 1;
    @(negedge clk);
    op = 4'd5; sel_d = 3'd5; use_imm = 1; start = 1;
    @(negedge clk);
    @(negedge clk);
    start = 0;
    c = 0;
    while (!done && c < 100) begin @(negedge clk); c++; end
    chk("R11", "done after interrupted-start mul", {31'h0, done}, 1);
    get_reg(3'd5, v);
    chk("R12", "target untouched", {16'h0, v}, 32'h0BAD);
    get_reg(3'd6, v6); get_reg(3'd7, v7);
    chk("R12", "product intact", {v6, v7}, 32'h0123 * 32'h0045);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule